// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the controller-side receiver of a time-slotted serial audio link. It runs on the link's bit clock (12.288 MHz in the target system) and generates the frame strobe `sync_o`. The strobe is high for the 16 bit times of the tag slot and low for the 240 bit times of the data slots. One frame lasts 256 bit clocks, so frames repeat at 48 kHz, roughly every 20.8 µs. The receiver samples the serial input on the falling edge of the bit clock. It splits each frame into a 16-bit tag slot (slot 0) and twelve 20-bit data slots (slots 1 to 12). Every slot arrives most significant bit first.

Slot 0 forms the tag phase. Its first bit says whether the remote codec is operational, and the block exposes that bit as `codec_ready_o` for polling. The next twelve bits mark slots 1 to 12 as holding valid data. The last three bits of slot 0 are discarded. The valid marks are gathered in a staging register. They are published on `slot_tags_o` only when the tag phase ends, and they then stay fixed through the data phase.

In the data phase, each data slot is delivered with a one-cycle strobe, its 20-bit word and its slot number. A slot is delivered only if three conditions hold: its valid mark is set, the frame's ready bit is set, and it is not slot 12. Slot 12 belongs to a modem function and is never delivered.

The sequence is run by a four-state machine. The states are:
- READY_BIT: bit 0, where the ready flag is captured.
- TAG_FLAGS: bits 1 to 12, where the slot marks are captured.
- TAG_SPARE: bits 13 to 15, which are discarded; the marks are published at the last of these bits.
- DATA: bits 16 to 255, the data slots.

Its transitions are:
- READY_BIT to TAG_FLAGS, always after one bit.
- TAG_FLAGS to TAG_SPARE, after bit 12.
- TAG_SPARE to DATA, after bit 15.
- DATA to READY_BIT, after bit 255, which wraps the frame.

Reset puts the machine in READY_BIT with the bit counter at 0.

Top module: `slot_frame_rx`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `sync_o` is 1, `codec_ready_o` is 0, `slot_tags_o` is all zero and `slot_valid_o` is 0. The first rising edge after release processes frame bit 0.
- R2: `sync_o` is high for the first 16 bit clocks of every frame and low for the following 240, giving a 256-clock frame period.
- R3: Frame bit 0 is the ready flag. `codec_ready_o` takes its value one cycle after that bit is processed and holds it until bit 0 of the next frame.
- R4: Frame bits 1 to 12 are the valid marks for slots 1 to 12, and the mark for slot k lands in `slot_tags_o[k-1]`. The new marks appear in the cycle after bit 15 and are unchanged until the same point of the next frame.
- R5: Frame bits 13 to 15 have no effect on any output.
- R6: Data is sampled on the falling edge of the bit clock. Slot s occupies bits 16+20(s-1) to 35+20(s-1), most significant bit first. A delivered slot raises `slot_valid_o` for exactly one cycle, in the cycle after its last bit, with the 20-bit word on `slot_data_o` and s on `slot_num_o`.
- R7: No slot is delivered in a frame whose ready flag is 0.
- R8: A slot whose valid mark is 0 is not delivered.
- R9: Slot 12 is never delivered, even when the ready flag and its valid mark are both 1.
- R10: Activity on `sdata_i` during the data phase does not change `slot_tags_o` or `codec_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial input data line |
| sync_o | output | 1 | Frame strobe, high during slot 0 |
| codec_ready_o | output | 1 | Ready flag of the latest frame |
| slot_tags_o | output | 12 | Valid marks of slots 1 to 12 (bit k-1 is slot k) |
| slot_valid_o | output | 1 | One-cycle strobe for a delivered data slot |
| slot_num_o | output | 4 | Number of the delivered slot (1 to 11) |
| slot_data_o | output | 20 | Word of the delivered slot |

## Verification
The bench drives each input bit in a short window around the falling edge and puts the inverted value on the line for the rest of the cycle. A receiver that samples on the rising edge therefore sees the complement of every bit, so its ready flag, marks and words all come out wrong. The bench sets the spare bits to patterns with ones in them, which catches a mark register that is one bit too long or is loaded at the wrong count. Frames with every mark set check that slot 11 is delivered and slot 12 is not, which catches an off-by-one in the slot range or in the reserved slot. Frames with the ready flag cleared check that nothing is delivered, which catches gating that uses a stale flag or none at all. A reset in the middle of a frame checks that the bit counter restarts, so the next frame is not split at the wrong boundary.

// File: rtl/slot_rx_pkg.sv
package slot_rx_pkg;

    // Frame phases; the order follows the bit order of a frame
    typedef enum logic [1:0] {
        ST_READY_BIT = 2'd0,
        ST_TAG_FLAGS = 2'd1,
        ST_TAG_SPARE = 2'd2,
        ST_DATA      = 2'd3
    } rx_state_t;

endpackage

// File: rtl/slot_rx_sampler.sv
// Captures the serial line on the falling edge of the bit clock.
module slot_rx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sdata_i,
    output logic bit_o
);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
        end else begin
            bit_o <= sdata_i;
        end
    end

endmodule

// File: rtl/slot_rx_counter.sv
// Frame position: absolute bit count, slot index and bit within data slot.
module slot_rx_counter #(
    parameter int TAG_BITS  = 16,
    parameter int DATA_BITS = 20,
    parameter int NUM_SLOTS = 12,
    localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * DATA_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(NUM_SLOTS + 1),
    localparam int SBIT_W     = $clog2(DATA_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              slot_end_o,
    output logic              frame_end_o
);

    logic [SBIT_W-1:0] sbit_q;

    assign frame_end_o = (cnt_o == CNT_W'(FRAME_BITS - 1));
    assign slot_end_o  = (slot_o != '0) && (sbit_q == SBIT_W'(DATA_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            slot_o <= '0;
            sbit_q <= '0;
        end else if (frame_end_o) begin
            cnt_o  <= '0;
            slot_o <= '0;
            sbit_q <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
            if (slot_o == '0) begin
                sbit_q <= '0;
                if (cnt_o == CNT_W'(TAG_BITS - 1)) begin
                    slot_o <= SLOT_W'(1);
                end
            end else if (slot_end_o) begin
                slot_o <= slot_o + 1'b1;
                sbit_q <= '0;
            end else begin
                sbit_q <= sbit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/slot_rx_shifter.sv
// Data-slot deserializer; word_o holds the slot including the bit now arriving.
module slot_rx_shifter #(
    parameter int DATA_BITS = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 bit_i,
    output logic [DATA_BITS-1:0] word_o
);

    logic [DATA_BITS-2:0] hist_q;

    assign word_o = {hist_q, bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[DATA_BITS-3:0], bit_i};
        end
    end

endmodule

// File: rtl/slot_frame_rx.sv
module slot_frame_rx
    import slot_rx_pkg::*;
#(
    parameter int TAG_BITS      = 16,
    parameter int DATA_BITS     = 20,
    parameter int NUM_SLOTS     = 12,
    parameter int RESERVED_SLOT = 12,
    localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * DATA_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 sdata_i,
    output logic                 sync_o,
    output logic                 codec_ready_o,
    output logic [NUM_SLOTS-1:0] slot_tags_o,
    output logic                 slot_valid_o,
    output logic [SLOT_W-1:0]    slot_num_o,
    output logic [DATA_BITS-1:0] slot_data_o
);

    rx_state_t             state_q, state_d;
    logic                  rx_bit;
    logic [CNT_W-1:0]      bit_cnt;
    logic [SLOT_W-1:0]     slot_idx;
    logic                  slot_end;
    logic                  frame_end;
    logic [DATA_BITS-1:0]  slot_word;
    logic [NUM_SLOTS-1:0]  tags_stage_q;
    logic                  tag_sel;
    logic                  deliver;

    slot_rx_sampler u_sampler (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .sdata_i (sdata_i),
        .bit_o   (rx_bit)
    );

    slot_rx_counter #(
        .TAG_BITS  (TAG_BITS),
        .DATA_BITS (DATA_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_counter (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .cnt_o       (bit_cnt),
        .slot_o      (slot_idx),
        .slot_end_o  (slot_end),
        .frame_end_o (frame_end)
    );

    slot_rx_shifter #(
        .DATA_BITS (DATA_BITS)
    ) u_shifter (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .shift_en (state_q == ST_DATA),
        .bit_i    (rx_bit),
        .word_o   (slot_word)
    );

    // Frame strobe: high through the whole tag phase
    assign sync_o = (state_q != ST_DATA);

    // Valid mark of the slot currently ending
    always_comb begin
        tag_sel = 1'b0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot_idx == SLOT_W'(k + 1)) begin
                tag_sel = slot_tags_o[k];
            end
        end
    end

    assign deliver = codec_ready_o && tag_sel
                     && (slot_idx != SLOT_W'(RESERVED_SLOT));

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY_BIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY_BIT: state_d = ST_TAG_FLAGS;
            ST_TAG_FLAGS: if (bit_cnt == CNT_W'(NUM_SLOTS)) state_d = ST_TAG_SPARE;
            ST_TAG_SPARE: if (bit_cnt == CNT_W'(TAG_BITS - 1)) state_d = ST_DATA;
            ST_DATA:      if (frame_end) state_d = ST_READY_BIT;
            default:      state_d = ST_READY_BIT;
        endcase
    end

    // Output and capture registers
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            codec_ready_o <= 1'b0;
            tags_stage_q  <= '0;
            slot_tags_o   <= '0;
            slot_valid_o  <= 1'b0;
            slot_num_o    <= '0;
            slot_data_o   <= '0;
        end else begin
            slot_valid_o <= 1'b0;
            unique case (state_q)
                ST_READY_BIT: codec_ready_o <= rx_bit;
                ST_TAG_FLAGS: begin
                    for (int k = 0; k < NUM_SLOTS; k++) begin
                        if (bit_cnt == CNT_W'(k + 1)) begin
                            tags_stage_q[k] <= rx_bit;
                        end
                    end
                end
                ST_TAG_SPARE: begin
                    if (bit_cnt == CNT_W'(TAG_BITS - 1)) begin
                        slot_tags_o <= tags_stage_q;
                    end
                end
                ST_DATA: begin
                    if (slot_end && deliver) begin
                        slot_valid_o <= 1'b1;
                        slot_num_o   <= slot_idx;
                        slot_data_o  <= slot_word;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

module slot_rx_checker #(
    parameter int TAG_BITS      = 16,
    parameter int DATA_BITS     = 20,
    parameter int NUM_SLOTS     = 12,
    parameter int RESERVED_SLOT = 12,
    localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * DATA_BITS,
    localparam int RUN_W      = $clog2(FRAME_BITS) + 1,
    localparam int SLOT_W     = $clog2(NUM_SLOTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_o,
    input logic                 codec_ready_o,
    input logic [NUM_SLOTS-1:0] slot_tags_o,
    input logic                 slot_valid_o,
    input logic [SLOT_W-1:0]    slot_num_o
);

    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sync_o ? hi_run + 1'b1 : '0;
            lo_run <= sync_o ? '0 : lo_run + 1'b1;
        end
    end

    // R2
    sync_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> (hi_run == RUN_W'(TAG_BITS)));

    // R2
    sync_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (lo_run == RUN_W'(FRAME_BITS - TAG_BITS)));

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_o && hi_run == RUN_W'(1)) |-> $stable(codec_ready_o));

    // R4
    tags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sync_o) |-> $stable(slot_tags_o));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |=> !slot_valid_o);

    // R7
    strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |-> codec_ready_o);

    // R8
    strobe_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |-> slot_tags_o[slot_num_o - 1'b1]);

    // R9
    strobe_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |-> (slot_num_o != '0 && slot_num_o != SLOT_W'(RESERVED_SLOT)));

endmodule

bind slot_frame_rx slot_rx_checker #(
    .TAG_BITS      (TAG_BITS),
    .DATA_BITS     (DATA_BITS),
    .NUM_SLOTS     (NUM_SLOTS),
    .RESERVED_SLOT (RESERVED_SLOT)
) u_chk (
    .clk           (bit_clk),
    .rst_n         (rst_n),
    .sync_o        (sync_o),
    .codec_ready_o (codec_ready_o),
    .slot_tags_o   (slot_tags_o),
    .slot_valid_o  (slot_valid_o),
    .slot_num_o    (slot_num_o)
);

// File: tb/test_slot_frame_rx.sv
`timescale 1ns/1ps
module test_slot_frame_rx;

    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        sdata_i = 1'b0;
    logic        sync_o;
    logic        codec_ready_o;
    logic [11:0] slot_tags_o;
    logic        slot_valid_o;
    logic [3:0]  slot_num_o;
    logic [19:0] slot_data_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    logic        prev_ready = 1'b0;
    logic [11:0] prev_tags  = '0;

    always #5 bit_clk = ~bit_clk;

    slot_frame_rx i_slot_frame_rx (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .sdata_i       (sdata_i),
        .sync_o        (sync_o),
        .codec_ready_o (codec_ready_o),
        .slot_tags_o   (slot_tags_o),
        .slot_valid_o  (slot_valid_o),
        .slot_num_o    (slot_num_o),
        .slot_data_o   (slot_data_o)
    );

    // Frame vectors: {ready, marks[12] (bit k-1 = slot k), spare[3], data seed[20]}
    localparam logic [35:0] FRAMES [8] = '{
        {1'b0, 12'hFFF, 3'b111, 20'h12345},
        {1'b1, 12'h000, 3'b000, 20'h0F0F0},
        {1'b1, 12'hFFF, 3'b111, 20'hABCDE},
        {1'b1, 12'h555, 3'b101, 20'h31415},
        {1'b1, 12'hAAA, 3'b010, 20'h27182},
        {1'b0, 12'h3C3, 3'b011, 20'hFFFFF},
        {1'b1, 12'h801, 3'b110, 20'h00001},
        {1'b1, 12'h400, 3'b100, 20'h5A5A5}
    };

    function automatic logic [19:0] word_of(input logic [19:0] seed, input int s);
        logic [19:0] sx;
        sx = 20'(s);
        return (seed ^ (sx * 20'h0B6E3)) + {sx[3:0], 16'h0};
    endfunction

    function automatic logic bit_of(input logic [35:0] fr, input int n);
        logic [11:0] tg;
        logic [2:0]  sp;
        logic [19:0] w;
        tg = fr[34:23];
        sp = fr[22:20];
        if (n == 0)  return fr[35];
        if (n <= 12) return tg[n-1];
        if (n <= 15) return sp[n-13];
        w = word_of(fr[19:0], (n - 16) / 20 + 1);
        return w[19 - ((n - 16) % 20)];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bit valid only around the falling edge; the complement fills the rest (R6)
    task automatic step(input logic b);
        sdata_i = b;
        @(negedge bit_clk);
        #1 sdata_i = ~b;
        @(posedge bit_clk);
        #1;
    endtask

    // Outputs expected while frame bit n is on the line
    task automatic check_at(input int n, input logic [35:0] fr);
        logic        e_ready;
        logic [11:0] e_tags;
        logic        e_valid;
        int          s;
        string       vreq;
        e_ready = (n >= 1)  ? fr[35]     : prev_ready;
        e_tags  = (n >= 16) ? fr[34:23]  : prev_tags;
        check(sync_o == (n < 16), "R2", "sync", int'(sync_o), int'(n < 16));
        check(codec_ready_o == e_ready, (n >= 16) ? "R10" : "R3", "ready",
              int'(codec_ready_o), int'(e_ready));
        if (n < 16)
            check(slot_tags_o == e_tags, "R4", "tags", int'(slot_tags_o), int'(e_tags));
        else if (n == 16)
            check(slot_tags_o == e_tags, (fr[22:20] != 0) ? "R5" : "R4", "tags",
                  int'(slot_tags_o), int'(e_tags));
        else
            check(slot_tags_o == e_tags, "R10", "tags", int'(slot_tags_o), int'(e_tags));
        e_valid = 1'b0;
        vreq = "R6";
        if (n == 0) begin
            vreq = "R9";
        end else if (n >= 36 && ((n - 16) % 20) == 0) begin
            s = (n - 16) / 20;
            e_valid = fr[35] && fr[23 + s - 1];
            if (!fr[35])            vreq = "R7";
            else if (!fr[23 + s - 1]) vreq = "R8";
            if (e_valid) begin
                check(slot_num_o == 4'(s), "R6", "slot number", int'(slot_num_o), s);
                check(slot_data_o == word_of(fr[19:0], s), "R6", "slot word",
                      int'(slot_data_o), int'(word_of(fr[19:0], s)));
            end
        end
        check(slot_valid_o == e_valid, vreq, "strobe", int'(slot_valid_o), int'(e_valid));
    endtask

    task automatic run_frame(input logic [35:0] fr, input int stop);
        for (int n = 0; n < stop; n++) begin
            check_at(n, fr);
            step(bit_of(fr, n));
        end
        if (stop == 256) begin
            prev_ready = fr[35];
            prev_tags  = fr[34:23];
        end
    endtask

    task automatic check_reset_state(input string what);
        check(sync_o == 1'b1, "R1", {what, " sync"}, int'(sync_o), 1);
        check(codec_ready_o == 1'b0, "R1", {what, " ready"}, int'(codec_ready_o), 0);
        check(slot_tags_o == 12'h000, "R1", {what, " tags"}, int'(slot_tags_o), 0);
        check(slot_valid_o == 1'b0, "R1", {what, " strobe"}, int'(slot_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge bit_clk);
        #1;
        check_reset_state("in reset");
        rst_n = 1'b1;

        // Table of frames, streamed back to back
        for (int f = 0; f < 8; f++) begin
            run_frame(FRAMES[f], 256);
        end

        // Reset in the middle of a data phase (R1)
        run_frame(FRAMES[2], 100);
        rst_n = 1'b0;
        #1;
        check_reset_state("mid-frame reset");
        prev_ready = 1'b0;
        prev_tags  = '0;
        repeat (2) @(posedge bit_clk);
        #1 rst_n = 1'b1;

        // Counter restarts at bit 0: full frames decode at the right boundaries
        run_frame(FRAMES[2], 256);
        run_frame(FRAMES[6], 256);
        check_at(0, FRAMES[0]);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule